// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a synchronous requester and an external asynchronous static RAM with two chip enables, a write strobe, an output enable and two byte-lane enables. The requester presents one read or one write at a time. The block then runs the memory strobes through a fixed sequence of phases, each lasting a whole number of clock cycles. Every phase length is rounded up from a nanosecond timing value and the clock period, all given as parameters. A busy flag covers the access and a one-cycle done pulse marks its end.

A read asserts both chip enables, the selected byte lanes and the output enable together. It holds them for the longest of the read-cycle, address-access and output-enable access times, and captures the data bus on the last cycle. A write has three phases: a setup cycle with address and enables valid, a write-strobe pulse, and a recovery phase. The block drives the data bus only after the memory's outputs have had time to switch off. Address, data and lane enables are registered when a request is taken and stay unchanged until the access ends.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, busy_o and done_o are 0, rdata_o is 0, the chip enable 1 is high, the chip enable 2 is low, the write and output strobes are high, both lane enables are high and sram_dq_oe_o is 0.
- R2: A request is taken only in a cycle where busy_o is 0 and req_i is 1, and busy_o rises on the following cycle. A request made while busy_o is 1 has no effect.
- R3: A read holds sram_ce1_n_o low, sram_ce2_o high, sram_oe_n_o low and sram_we_n_o high for RD cycles (18 at the default 4 ns clock). The lane enables follow req_lane_en_i, where bit 1 drives sram_ub_n_o for bits 15:8, bit 0 drives sram_lb_n_o for bits 7:0, and 1 means enabled.
- R4: The data bus is captured at the end of the last read cycle. Enabled lanes are taken from sram_dq_i and disabled lanes read as zero. rdata_o holds its value until the next read completes.
- R5: A write is one setup cycle with the enables asserted and sram_we_n_o high, then sram_we_n_o low for 15 cycles, then 2 recovery cycles with sram_we_n_o high and the enables still asserted. sram_oe_n_o stays high throughout.
- R6: sram_dq_oe_o is asserted only during a write. It rises 7 cycles after sram_we_n_o falls and stays asserted through recovery, so the data is valid for at least 8 cycles before the strobe rises. It is never asserted while sram_oe_n_o is low.
- R7: sram_addr_o, sram_dq_o and the lane enables stay constant while the chip enables are asserted. Changes on the request inputs during an access do not reach them.
- R8: done_o is a single-cycle pulse in the first cycle after each access, in which busy_o is 0.
- R9: Between two accesses there is at least one cycle with the chip enables deasserted, even when req_i stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Write data |
| req_lane_en_i | input | 2 | Byte lanes, bit 1 upper, bit 0 lower, 1 = enabled |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle end-of-access pulse |
| rdata_o | output | DW | Captured read data |
| sram_addr_o | output | AW | Memory address |
| sram_ce1_n_o | output | 1 | Chip enable 1, active low |
| sram_ce2_o | output | 1 | Chip enable 2, active high |
| sram_we_n_o | output | 1 | Write strobe, active low |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_ub_n_o | output | 1 | Upper lane enable, active low |
| sram_lb_n_o | output | 1 | Lower lane enable, active low |
| sram_dq_o | output | DW | Write data to the bus |
| sram_dq_oe_o | output | 1 | Data bus drive enable |
| sram_dq_i | input | DW | Data from the bus |

## Verification
The assertions check on every cycle the properties that hold at all times:
- the output enable stays off while the write strobe is low;
- the bus is never driven against the memory's outputs;
- the write strobe is low for exactly the pulse length;
- the bus drive waits out the turnaround;
- the address is frozen while the memory is selected;
- done falls in an idle cycle with the enables released.

Only the bench scenarios can show the rest:
- each phase lasts the right number of cycles;
- data written with partial lane masks reads back correctly;
- read data is sampled no earlier than the access time allows;
- a request made during an access is dropped;
- a request held high runs back-to-back with exactly one idle cycle between accesses.

// File: rtl/sram_timing_pkg.sv
package sram_timing_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER
  } ctrl_state_e;

  function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [LANES-1:0] lane_en_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    rdata_o
);

  localparam int LW = DW / LANES;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lane_q <= '0;
      else if (cap_i) lane_q <= lane_en_i[l] ? dq_i[l*LW +: LW] : '0;
    end
    assign rdata_o[l*LW +: LW] = lane_q;
  end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_timing_pkg::*;
#(
  parameter int AW       = 19,
  parameter int DW       = 16,
  parameter int CLK_PS   = 4000,
  parameter int T_RC_PS  = 70000,
  parameter int T_AA_PS  = 70000,
  parameter int T_OE_PS  = 35000,
  parameter int T_WC_PS  = 70000,
  parameter int T_AW_PS  = 60000,
  parameter int T_CW_PS  = 60000,
  parameter int T_WP_PS  = 50000,
  parameter int T_DW_PS  = 30000,
  parameter int T_WZ_PS  = 25000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [1:0]    req_lane_en_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_ce1_n_o,
  output logic          sram_ce2_o,
  output logic          sram_we_n_o,
  output logic          sram_oe_n_o,
  output logic          sram_ub_n_o,
  output logic          sram_lb_n_o,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i
);

  localparam int RD_CYC       = imax(ps_to_cyc(T_RC_PS, CLK_PS),
                                imax(ps_to_cyc(T_AA_PS, CLK_PS), ps_to_cyc(T_OE_PS, CLK_PS)));
  localparam int SETUP_CYC    = 1;
  localparam int TURN_CYC     = ps_to_cyc(T_WZ_PS, CLK_PS);
  localparam int DSU_CYC      = ps_to_cyc(T_DW_PS, CLK_PS);
  localparam int WR_PULSE_CYC = imax(ps_to_cyc(T_WP_PS, CLK_PS),
                                imax(ps_to_cyc(T_AW_PS, CLK_PS) - SETUP_CYC,
                                imax(ps_to_cyc(T_CW_PS, CLK_PS) - SETUP_CYC, TURN_CYC + DSU_CYC)));
  localparam int RECOV_CYC    = imax(1, ps_to_cyc(T_WC_PS, CLK_PS) - SETUP_CYC - WR_PULSE_CYC);
  localparam int MAX_CYC      = imax(RD_CYC, imax(WR_PULSE_CYC, RECOV_CYC));
  localparam int CNT_W        = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] DRV_FROM = CNT_W'(WR_PULSE_CYC - 1 - TURN_CYC);

  ctrl_state_e      state_q, state_d;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [1:0]       lane_q;
  logic             done_q, done_d;
  logic             load;
  logic [CNT_W-1:0] load_val, cnt;
  logic             last, cap, accept, active;

  assign accept = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    done_d   = 1'b0;
    cap      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        load = 1'b1;
        if (req_we_i) begin
          state_d  = ST_WR_SETUP;
          load_val = CNT_W'(SETUP_CYC - 1);
        end else begin
          state_d  = ST_RD;
          load_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_RD: if (last) begin
        state_d = ST_IDLE;
        cap     = 1'b1;
        done_d  = 1'b1;
      end
      ST_WR_SETUP: if (last) begin
        state_d  = ST_WR_PULSE;
        load     = 1'b1;
        load_val = CNT_W'(WR_PULSE_CYC - 1);
      end
      ST_WR_PULSE: if (last) begin
        state_d  = ST_WR_RECOVER;
        load     = 1'b1;
        load_val = CNT_W'(RECOV_CYC - 1);
      end
      ST_WR_RECOVER: if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      lane_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        lane_q  <= req_lane_en_i;
      end
    end
  end

  sram_cycle_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .cnt_o      (cnt),
    .last_o     (last)
  );

  sram_rd_capture #(.DW(DW), .LANES(2)) i_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .lane_en_i (lane_q),
    .dq_i      (sram_dq_i),
    .rdata_o   (rdata_o)
  );

  assign active       = (state_q != ST_IDLE);
  assign busy_o       = active;
  assign done_o       = done_q;
  assign sram_addr_o  = addr_q;
  assign sram_dq_o    = wdata_q;
  assign sram_ce1_n_o = ~active;
  assign sram_ce2_o   = active;
  assign sram_ub_n_o  = ~(active & lane_q[1]);
  assign sram_lb_n_o  = ~(active & lane_q[0]);
  assign sram_we_n_o  = (state_q != ST_WR_PULSE);
  assign sram_oe_n_o  = (state_q != ST_RD);
  // drive only after the memory's outputs have released the bus
  assign sram_dq_oe_o = ((state_q == ST_WR_PULSE) && (cnt <= DRV_FROM)) ||
                        (state_q == ST_WR_RECOVER);

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int AW        = 19,
  parameter int PULSE_CYC = 15,
  parameter int TURN_CYC  = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          sram_ce1_n_o,
  input logic          sram_we_n_o,
  input logic          sram_oe_n_o,
  input logic          sram_dq_oe_o,
  input logic [AW-1:0] sram_addr_o
);

  int we_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           we_low_cnt <= 0;
    else if (!sram_we_n_o) we_low_cnt <= we_low_cnt + 1;
    else                   we_low_cnt <= 0;
  end

  a_r5_oe_off_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> sram_oe_n_o);

  a_r5_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_n_o) |-> (we_low_cnt == PULSE_CYC));

  a_r6_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_n_o);

  a_r6_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_n_o && (we_low_cnt < TURN_CYC)) |-> !sram_dq_oe_o);

  a_r7_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce1_n_o && $past(!sram_ce1_n_o)) |-> $stable(sram_addr_o));

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));

  a_r9_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sram_ce1_n_o);

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .AW        (AW),
  .PULSE_CYC (WR_PULSE_CYC),
  .TURN_CYC  (TURN_CYC)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .sram_ce1_n_o (sram_ce1_n_o),
  .sram_we_n_o  (sram_we_n_o),
  .sram_oe_n_o  (sram_oe_n_o),
  .sram_dq_oe_o (sram_dq_oe_o),
  .sram_addr_o  (sram_addr_o)
);

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;

  localparam int AW = 19;
  localparam int DW = 16;
  localparam int RD_N = 18, PULSE_N = 15, TURN_N = 7, DSU_N = 8, REC_N = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_lane = '0;
  logic          busy, done, ce1_n, ce2, we_n, oe_n, ub_n, lb_n, dq_oe;
  logic [DW-1:0] rdata, dq_o;
  logic [DW-1:0] dq_i = '0;
  logic [AW-1:0] s_addr;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sram_strobe_ctrl i_sram_strobe_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_lane_en_i(req_lane),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .sram_addr_o(s_addr),
    .sram_ce1_n_o(ce1_n), .sram_ce2_o(ce2), .sram_we_n_o(we_n), .sram_oe_n_o(oe_n),
    .sram_ub_n_o(ub_n), .sram_lb_n_o(lb_n), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe),
    .sram_dq_i(dq_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference model: per-cycle phase codes
  // 0 idle, 1 read, 2 wr setup, 3 pulse no drive, 4 pulse drive, 5 recovery, 6 done/idle
  int q[$];
  int cur = 0;
  logic [AW-1:0] e_addr = '0;
  logic [DW-1:0] e_wdata = '0;
  logic [1:0]    e_lane = '0;
  logic [DW-1:0] e_rdata = '0;
  logic [DW-1:0] ref_mem [int];
  int exp_done = 0, seen_done = 0;

  function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'hFFFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cur = 0;
      q.delete();
    end else begin
      int prev;
      prev = cur;
      cur = (q.size() > 0) ? q.pop_front() : 0;
      if ((prev == 0 || prev == 6) && req) begin
        logic [DW-1:0] m;
        e_addr = req_addr; e_wdata = req_wdata; e_lane = req_lane;
        exp_done++;
        m = ref_rd(req_addr);
        if (req_we) begin
          if (req_lane[1]) m[15:8] = req_wdata[15:8];
          if (req_lane[0]) m[7:0]  = req_wdata[7:0];
          ref_mem[int'(req_addr)] = m;
          q.push_back(2);
          for (int i = 0; i < TURN_N; i++) q.push_back(3);
          for (int i = 0; i < PULSE_N - TURN_N; i++) q.push_back(4);
          for (int i = 0; i < REC_N; i++) q.push_back(5);
        end else begin
          e_rdata = {req_lane[1] ? m[15:8] : 8'h00, req_lane[0] ? m[7:0] : 8'h00};
          for (int i = 0; i < RD_N; i++) q.push_back(1);
        end
        q.push_back(6);
        cur = q.pop_front();
      end
    end
  end

  // behavioural SRAM with timing checks
  logic [DW-1:0] smem [int];
  int rd_age = 0, we_low = 0, drv_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [DW-1:0] m;
      m = smem.exists(int'(s_addr)) ? smem[int'(s_addr)] : 16'hFFFF;
      if (dq_oe && !oe_n) chk(0, "R6 bus contention", 1, 0);
      if (!ce1_n && ce2 && !oe_n) rd_age++; else rd_age = 0;
      if (rd_age >= RD_N)
        dq_i = {ub_n ? 8'hEE : m[15:8], lb_n ? 8'hEE : m[7:0]};
      else
        dq_i = 16'hBAD0;
      if (!we_n) begin
        we_low++;
        if (dq_oe) drv_cnt++;
      end else if (we_low > 0) begin
        chk(we_low >= 13, "R5 write pulse width", we_low, 13);
        chk(drv_cnt >= DSU_N, "R6 data setup", drv_cnt, DSU_N);
        if (!ub_n) m[15:8] = dq_o[15:8];
        if (!lb_n) m[7:0]  = dq_o[7:0];
        smem[int'(s_addr)] = m;
        we_low = 0; drv_cnt = 0;
      end
      if (done) seen_done++;
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      bit act;
      act = (cur != 0) && (cur != 6);
      chk(busy == act, "R2 busy", busy, act);
      chk(done == (cur == 6), "R8 done", done, cur == 6);
      chk(ce1_n == !act && ce2 == act, "R9 chip enables", {ce1_n, ce2}, {!act, act});
      chk(ub_n == !(act && e_lane[1]) && lb_n == !(act && e_lane[0]), "R3 lane enables",
          {ub_n, lb_n}, {!(act && e_lane[1]), !(act && e_lane[0])});
      chk(oe_n == (cur != 1), "R3 output enable", oe_n, cur != 1);
      chk(we_n == !(cur == 3 || cur == 4), "R5 write strobe", we_n, !(cur == 3 || cur == 4));
      chk(dq_oe == (cur == 4 || cur == 5), "R6 drive enable", dq_oe, cur == 4 || cur == 5);
      chk(s_addr == e_addr, "R7 address", s_addr, e_addr);
      if (dq_oe) chk(dq_o == e_wdata, "R7 write data", dq_o, e_wdata);
    end
  end

  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] ln);
    @(negedge clk);
    req = 1; req_we = we; req_addr = a; req_wdata = d; req_lane = ln;
    @(negedge clk);
    req = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (cur != 6);
  endtask

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] ln);
    issue(we, a, d, ln);
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && rdata == 0, "R1 status", {busy, done, rdata}, 0);
    chk(ce1_n && !ce2 && we_n && oe_n && ub_n && lb_n && !dq_oe, "R1 strobes",
        {ce1_n, ce2, we_n, oe_n, ub_n, lb_n, dq_oe}, 7'b1011110);

    access(1, 19'h00012, 16'h1234, 2'b11);
    access(0, 19'h00012, 16'h0000, 2'b11);
    chk(rdata == 16'h1234, "R4 full word", rdata, 16'h1234);

    access(1, 19'h7FFFF, 16'hABCD, 2'b01);
    access(0, 19'h7FFFF, 16'h0000, 2'b11);
    chk(rdata == 16'hFFCD, "R4 lower-lane write", rdata, 16'hFFCD);

    access(0, 19'h00012, 16'h0000, 2'b10);
    chk(rdata == 16'h1200, "R4 upper lane only", rdata, 16'h1200);
    access(0, 19'h00012, 16'h0000, 2'b01);
    chk(rdata == 16'h0034, "R4 lower lane only", rdata, 16'h0034);

    // R2: request during a read is dropped
    issue(0, 19'h7FFFF, 16'h0000, 2'b11);
    repeat (5) @(negedge clk);
    req = 1; req_we = 1; req_addr = 19'h00012; req_wdata = 16'h0000; req_lane = 2'b11;
    @(negedge clk);
    req = 0;
    wait_done();
    chk(rdata == 16'hFFCD, "R2 read during busy", rdata, 16'hFFCD);
    repeat (3) @(negedge clk);
    chk(!busy, "R2 no extra access", busy, 0);
    access(0, 19'h00012, 16'h0000, 2'b11);
    chk(rdata == 16'h1234, "R2 ignored write left memory", rdata, 16'h1234);

    // R9/R7: req held high, fields change mid-access
    @(negedge clk);
    req = 1; req_we = 1; req_addr = 19'h00040; req_wdata = 16'h5A5A; req_lane = 2'b11;
    @(negedge clk);
    req_we = 0; req_addr = 19'h00012; req_wdata = 16'hFFFF;
    wait_done();
    chk(ce1_n, "R9 idle gap", ce1_n, 1);
    @(negedge clk);
    req = 0;
    chk(busy && !oe_n, "R9 back-to-back start", {busy, oe_n}, 2'b10);
    wait_done();
    chk(rdata == 16'h1234, "R7 second access", rdata, 16'h1234);
    access(0, 19'h00040, 16'h0000, 2'b11);
    chk(rdata == 16'h5A5A, "R7 write kept its fields", rdata, 16'h5A5A);

    repeat (4) @(negedge clk);
    chk(seen_done == exp_done, "R8 done count", seen_done, exp_done);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule